// File: doc/BRIEF.md
# Zero-Overhead Loop Fetch Sequencer

This block produces the instruction fetch address for a small processor front end on every clock cycle. Counted loops run without branch or decrement instructions. A loop-setup request carries the first address of the loop body, the last address of the body and the number of passes. The sequencer keeps these on a nested loop stack. Whenever the address being fetched equals the last-address field of the innermost loop, the sequencer chooses the next address in the same cycle, so closing a loop costs no cycles.

An arbitrary jump is requested with a branch input and target. The jump has priority over sequential fetch and over the loop test. Alongside the fetch stage the block records the address and a valid bit for the decode and execute stages of a three-stage pipeline. A jump clears the valid bits of the instructions already in flight. Instruction decoding, the program memory and interrupt handling are left to neighbouring blocks.

Top module: `zol_seq`

## Requirements
- R1: While reset is held, fetch_pc is 0, fetch_valid, dec_valid and exe_valid are 0, loop_depth is 0 and loop_ovf is 0. On the first clock after reset is released, fetch_valid becomes 1 and fetch_pc stays 0.
- R2: With fetch_valid high, no branch, and no loop end matched, fetch_pc advances by one on each clock.
- R3: If the fetched address equals the innermost loop's last address and that loop's remaining count is above 1, the next fetch_pc is the loop's first address. The count drops by one, and no invalid cycle is inserted.
- R4: If the fetched address equals the innermost loop's last address and its remaining count is 1, the next fetch_pc is that last address plus 1, and loop_depth drops by one.
- R5: A setup request with a count of 0 is stored as a count of 1, so the body runs exactly once.
- R6: Loops nest. Only the innermost entry is tested. When it retires, the enclosing loop resumes its own testing, and loop_depth never exceeds DEPTH (6 by default).
- R7: A setup request that arrives when the stack already holds DEPTH entries is dropped, and loop_ovf goes high. The stored entries and loop_depth are unchanged. loop_ovf stays high until reset.
- R8: When br_valid is high, the next fetch_pc is br_target and dec_valid and exe_valid go low on that clock. The loop stack is not modified, even if the fetched address is a loop end.
- R9: On each clock, dec_pc takes the old fetch_pc and exe_pc takes the old dec_pc. dec_valid takes the old fetch_valid and exe_valid takes the old dec_valid, both cleared by a branch.
- R10: If a setup request arrives in the same cycle that the innermost loop retires, the retired entry is removed and the new entry is pushed in its place. loop_depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| setup_valid | input | 1 | Push a new loop this cycle |
| setup_start | input | AW | First address of the loop body |
| setup_end | input | AW | Last address of the loop body |
| setup_count | input | CW | Number of passes (0 is taken as 1) |
| br_valid | input | 1 | Jump to br_target next cycle |
| br_target | input | AW | Jump destination |
| fetch_pc | output | AW | Address being fetched |
| fetch_valid | output | 1 | Fetch stage holds a live address |
| dec_pc | output | AW | Address in the decode stage |
| dec_valid | output | 1 | Decode stage is live |
| exe_pc | output | AW | Address in the execute stage |
| exe_valid | output | 1 | Execute stage is live |
| loop_depth | output | clog2(DEPTH+1) | Number of active loops |
| loop_ovf | output | 1 | Sticky loop stack overflow flag |

## Verification
The bench targets the wrap cycle first. A design that tests the count off by one runs one pass too many or too few, and a design that wraps one cycle late shows a stray end+1 fetch or a bubble in dec_pc. Nested loops with a repeated inner setup would expose a stack that tests the outer entry, or that loses the outer count when the inner entry pops. The bench also pushes onto a full stack and then runs the top loop, which shows whether the ignored request overwrote the sixth entry. It branches out of a loop-end address to check that the stack is not popped, and it pushes in the same cycle as a pop to catch a depth that drifts or an entry that is written into the wrong slot.

// File: rtl/zol_pkg.sv
package zol_pkg;

   // source of the next fetch address
   typedef enum logic [2:0] {
      NXT_HOLD,
      NXT_SEQ,
      NXT_LOOP,
      NXT_EXIT,
      NXT_JUMP
   } nxt_sel_e;

endpackage

// File: rtl/zol_loop_stack.sv
module zol_loop_stack #(
   parameter int AW            = 16,
   parameter int CW            = 16,
   parameter int DEPTH         = 6,
   parameter bit CLEAR_ENTRIES = 1'b1,
   localparam int PW           = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_start,
   input  logic [AW-1:0] push_end,
   input  logic [CW-1:0] push_cnt,
   input  logic          pop,
   input  logic          dec_top,
   output logic          top_valid,
   output logic [AW-1:0] top_start,
   output logic [AW-1:0] top_end,
   output logic [CW-1:0] top_cnt,
   output logic [PW-1:0] depth,
   output logic          ovf
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("zol_loop_stack: DEPTH must be at least 1");
   end
   if (CW < 2) begin : g_bad_cw
      $error("zol_loop_stack: CW must be at least 2");
   end

   logic [PW-1:0]                depth_q;
   logic                         ovf_q;
   logic [PW-1:0]                depth_after_pop;
   logic                         push_ok;
   logic [CW-1:0]                load_cnt;
   logic [DEPTH-1:0][AW-1:0]     start_v;
   logic [DEPTH-1:0][AW-1:0]     end_v;
   logic [DEPTH-1:0][CW-1:0]     cnt_v;

   always_comb begin
      depth_after_pop = (pop && depth_q != '0) ? depth_q - PW'(1) : depth_q;
      push_ok         = push && (depth_after_pop < PW'(DEPTH));
      load_cnt        = (push_cnt == '0) ? CW'(1) : push_cnt;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [AW-1:0] s_q;
      logic [AW-1:0] e_q;
      logic [CW-1:0] c_q;
      logic          wr_here;
      logic          dec_here;

      assign wr_here  = push_ok && (depth_after_pop == PW'(i));
      assign dec_here = dec_top && (depth_q == PW'(i + 1));

      if (CLEAR_ENTRIES) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= '0;
               e_q <= '0;
               c_q <= '0;
            end else if (wr_here) begin
               s_q <= push_start;
               e_q <= push_end;
               c_q <= load_cnt;
            end else if (dec_here) begin
               c_q <= c_q - CW'(1);
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_here) begin
               s_q <= push_start;
               e_q <= push_end;
               c_q <= load_cnt;
            end else if (dec_here) begin
               c_q <= c_q - CW'(1);
            end
         end
      end

      assign start_v[i] = s_q;
      assign end_v[i]   = e_q;
      assign cnt_v[i]   = c_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         depth_q <= push_ok ? depth_after_pop + PW'(1) : depth_after_pop;
         ovf_q   <= ovf_q | (push & ~push_ok);
      end
   end

   always_comb begin
      top_start = '0;
      top_end   = '0;
      top_cnt   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (depth_q == PW'(i + 1)) begin
            top_start = start_v[i];
            top_end   = end_v[i];
            top_cnt   = cnt_v[i];
         end
      end
   end

   assign top_valid = (depth_q != '0);
   assign depth     = depth_q;
   assign ovf       = ovf_q;

endmodule

// File: rtl/zol_next_pc.sv
module zol_next_pc
   import zol_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic [AW-1:0] fetch_pc,
   input  logic          fetch_valid,
   input  logic          br_valid,
   input  logic [AW-1:0] br_target,
   input  logic          top_valid,
   input  logic [AW-1:0] top_start,
   input  logic [AW-1:0] top_end,
   input  logic [CW-1:0] top_cnt,
   output logic [AW-1:0] nxt_pc,
   output logic          dec_top,
   output logic          pop
);

   nxt_sel_e sel;
   logic     at_end;
   logic     more_passes;

   always_comb begin
      at_end      = fetch_valid && top_valid && (fetch_pc == top_end);
      more_passes = (top_cnt > CW'(1));

      if (br_valid)          sel = NXT_JUMP;
      else if (!fetch_valid) sel = NXT_HOLD;
      else if (at_end)       sel = more_passes ? NXT_LOOP : NXT_EXIT;
      else                   sel = NXT_SEQ;

      unique case (sel)
         NXT_JUMP: nxt_pc = br_target;
         NXT_HOLD: nxt_pc = fetch_pc;
         NXT_LOOP: nxt_pc = top_start;
         NXT_EXIT: nxt_pc = top_end + AW'(1);
         default:  nxt_pc = fetch_pc + AW'(1);
      endcase

      dec_top = (sel == NXT_LOOP);
      pop     = (sel == NXT_EXIT);
   end

endmodule

// File: rtl/zol_pipe_track.sv
module zol_pipe_track #(
   parameter int AW     = 16,
   parameter int STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [AW-1:0]               in_pc,
   input  logic                        in_valid,
   input  logic                        flush,
   output logic [STAGES-1:0][AW-1:0]   pc_o,
   output logic [STAGES-1:0]           valid_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("zol_pipe_track: STAGES must be at least 1");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stg
      logic [AW-1:0] src_pc;
      logic          src_v;
      logic [AW-1:0] pc_q;
      logic          v_q;

      if (k == 0) begin : g_head
         assign src_pc = in_pc;
         assign src_v  = in_valid;
      end else begin : g_tail
         assign src_pc = pc_o[k-1];
         assign src_v  = valid_o[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q <= '0;
            v_q  <= 1'b0;
         end else begin
            pc_q <= src_pc;
            v_q  <= src_v & ~flush;
         end
      end

      assign pc_o[k]    = pc_q;
      assign valid_o[k] = v_q;
   end

endmodule

// File: rtl/zol_seq.sv
module zol_seq #(
   parameter int AW            = 16,
   parameter int CW            = 16,
   parameter int DEPTH         = 6,
   parameter bit CLEAR_ENTRIES = 1'b1,
   localparam int PW           = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          setup_valid,
   input  logic [AW-1:0] setup_start,
   input  logic [AW-1:0] setup_end,
   input  logic [CW-1:0] setup_count,
   input  logic          br_valid,
   input  logic [AW-1:0] br_target,
   output logic [AW-1:0] fetch_pc,
   output logic          fetch_valid,
   output logic [AW-1:0] dec_pc,
   output logic          dec_valid,
   output logic [AW-1:0] exe_pc,
   output logic          exe_valid,
   output logic [PW-1:0] loop_depth,
   output logic          loop_ovf
);

   localparam int TRAIL = 2;

   if (AW < 2) begin : g_bad_aw
      $error("zol_seq: AW must be at least 2");
   end

   logic [AW-1:0]            fetch_pc_q;
   logic                     fetch_valid_q;
   logic [AW-1:0]            nxt_pc;
   logic                     dec_top;
   logic                     pop;
   logic                     top_valid;
   logic [AW-1:0]            top_start;
   logic [AW-1:0]            top_end;
   logic [CW-1:0]            top_cnt;
   logic [TRAIL-1:0][AW-1:0] trk_pc;
   logic [TRAIL-1:0]         trk_v;

   zol_loop_stack #(
      .AW(AW), .CW(CW), .DEPTH(DEPTH), .CLEAR_ENTRIES(CLEAR_ENTRIES)
   ) stack_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (setup_valid),
      .push_start (setup_start),
      .push_end   (setup_end),
      .push_cnt   (setup_count),
      .pop        (pop),
      .dec_top    (dec_top),
      .top_valid  (top_valid),
      .top_start  (top_start),
      .top_end    (top_end),
      .top_cnt    (top_cnt),
      .depth      (loop_depth),
      .ovf        (loop_ovf)
   );

   zol_next_pc #(.AW(AW), .CW(CW)) npc_i (
      .fetch_pc    (fetch_pc_q),
      .fetch_valid (fetch_valid_q),
      .br_valid    (br_valid),
      .br_target   (br_target),
      .top_valid   (top_valid),
      .top_start   (top_start),
      .top_end     (top_end),
      .top_cnt     (top_cnt),
      .nxt_pc      (nxt_pc),
      .dec_top     (dec_top),
      .pop         (pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_pc_q    <= '0;
         fetch_valid_q <= 1'b0;
      end else begin
         fetch_pc_q    <= nxt_pc;
         fetch_valid_q <= 1'b1;
      end
   end

   zol_pipe_track #(.AW(AW), .STAGES(TRAIL)) trk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_pc    (fetch_pc_q),
      .in_valid (fetch_valid_q),
      .flush    (br_valid),
      .pc_o     (trk_pc),
      .valid_o  (trk_v)
   );

   assign fetch_pc    = fetch_pc_q;
   assign fetch_valid = fetch_valid_q;
   assign dec_pc      = trk_pc[0];
   assign dec_valid   = trk_v[0];
   assign exe_pc      = trk_pc[1];
   assign exe_valid   = trk_v[1];

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int DEPTH = 6,
   localparam int PW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          br_valid,
   input logic [AW-1:0] br_target,
   input logic [AW-1:0] fetch_pc,
   input logic          fetch_valid,
   input logic [AW-1:0] dec_pc,
   input logic          dec_valid,
   input logic          exe_valid,
   input logic [PW-1:0] loop_depth,
   input logic          loop_ovf,
   input logic          top_valid,
   input logic [AW-1:0] top_start,
   input logic [AW-1:0] top_end,
   input logic [CW-1:0] top_cnt
);

   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fetch_pc == '0) && !fetch_valid && !dec_valid && !exe_valid
                       && (loop_depth == '0) && !loop_ovf);

   a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !br_valid && !top_valid) |=> fetch_pc == $past(fetch_pc) + AW'(1));

   a_r3_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !br_valid && top_valid && fetch_pc == top_end && top_cnt > CW'(1))
      |=> fetch_pc == $past(top_start));

   a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !br_valid && top_valid && fetch_pc == top_end && top_cnt == CW'(1))
      |=> fetch_pc == $past(top_end) + AW'(1));

   a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      loop_depth <= PW'(DEPTH));

   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      loop_ovf |=> loop_ovf);

   a_r8_branch_flush: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |=> (fetch_pc == $past(br_target)) && !dec_valid && !exe_valid);

   a_r8_branch_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && loop_depth == PW'(DEPTH)) |=> loop_depth == PW'(DEPTH));

   a_r9_decode_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !br_valid) |=> dec_valid && (dec_pc == $past(fetch_pc)));

endmodule

bind zol_seq zol_seq_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/zol_seq_tb.sv
module zol_seq_tb_top;

   localparam int AW    = 16;
   localparam int CW    = 16;
   localparam int DEPTH = 6;
   localparam int PW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          setup_valid = 1'b0;
   logic [AW-1:0] setup_start = '0;
   logic [AW-1:0] setup_end = '0;
   logic [CW-1:0] setup_count = '0;
   logic          br_valid = 1'b0;
   logic [AW-1:0] br_target = '0;
   logic [AW-1:0] fetch_pc;
   logic          fetch_valid;
   logic [AW-1:0] dec_pc;
   logic          dec_valid;
   logic [AW-1:0] exe_pc;
   logic          exe_valid;
   logic [PW-1:0] loop_depth;
   logic          loop_ovf;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   zol_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .setup_valid(setup_valid), .setup_start(setup_start),
      .setup_end(setup_end), .setup_count(setup_count),
      .br_valid(br_valid), .br_target(br_target),
      .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
      .dec_pc(dec_pc), .dec_valid(dec_valid),
      .exe_pc(exe_pc), .exe_valid(exe_valid),
      .loop_depth(loop_depth), .loop_ovf(loop_ovf)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic expect_pc(input int exp, input string tag);
      tick();
      chk(tag, "fetch_pc", int'(fetch_pc), exp);
   endtask

   task automatic push_and_tick(input int s, input int e, input int c);
      setup_valid = 1'b1;
      setup_start = AW'(s);
      setup_end   = AW'(e);
      setup_count = CW'(c);
      tick();
      setup_valid = 1'b0;
   endtask

   task automatic branch_and_tick(input int t);
      br_valid  = 1'b1;
      br_target = AW'(t);
      tick();
      br_valid  = 1'b0;
   endtask

   // R1: reset values, then first fetch at address 0
   task automatic do_reset();
      rst_n       = 1'b0;
      setup_valid = 1'b0;
      br_valid    = 1'b0;
      tick();
      tick();
      chk("R1", "fetch_pc in reset", int'(fetch_pc), 0);
      chk("R1", "fetch_valid in reset", int'(fetch_valid), 0);
      chk("R1", "dec_valid in reset", int'(dec_valid), 0);
      chk("R1", "exe_valid in reset", int'(exe_valid), 0);
      chk("R1", "loop_depth in reset", int'(loop_depth), 0);
      chk("R1", "loop_ovf in reset", int'(loop_ovf), 0);
      rst_n = 1'b1;
      tick();
      chk("R1", "fetch_valid after release", int'(fetch_valid), 1);
      chk("R1", "fetch_pc after release", int'(fetch_pc), 0);
   endtask

   // R2 and R9: straight-line fetch and stage tracking
   task automatic test_sequential();
      do_reset();
      expect_pc(1, "R2");
      chk("R9", "dec_pc", int'(dec_pc), 0);
      chk("R9", "dec_valid", int'(dec_valid), 1);
      chk("R9", "exe_valid", int'(exe_valid), 0);
      expect_pc(2, "R2");
      chk("R9", "dec_pc", int'(dec_pc), 1);
      chk("R9", "exe_pc", int'(exe_pc), 0);
      chk("R9", "exe_valid", int'(exe_valid), 1);
      expect_pc(3, "R2");
      expect_pc(4, "R2");
   endtask

   // R3 and R4: three passes over 2..4
   task automatic test_single_loop();
      do_reset();
      push_and_tick(2, 4, 3);
      chk("R3", "fetch_pc", int'(fetch_pc), 1);
      chk("R3", "loop_depth", int'(loop_depth), 1);
      expect_pc(2, "R3");
      expect_pc(3, "R3");
      expect_pc(4, "R3");
      expect_pc(2, "R3");
      chk("R3", "fetch_valid at wrap", int'(fetch_valid), 1);
      chk("R3", "dec_pc at wrap", int'(dec_pc), 4);
      expect_pc(3, "R3");
      expect_pc(4, "R3");
      expect_pc(2, "R3");
      expect_pc(3, "R3");
      expect_pc(4, "R3");
      chk("R3", "loop_depth on last pass", int'(loop_depth), 1);
      expect_pc(5, "R4");
      chk("R4", "loop_depth after exit", int'(loop_depth), 0);
      expect_pc(6, "R2");
   endtask

   // R5: count 0 runs once
   task automatic test_zero_count();
      do_reset();
      push_and_tick(1, 2, 0);
      chk("R5", "loop_depth", int'(loop_depth), 1);
      expect_pc(2, "R5");
      expect_pc(3, "R5");
      chk("R5", "loop_depth after single pass", int'(loop_depth), 0);
   endtask

   // R6: inner 2..3 (x2) inside outer 1..6 (x2)
   task automatic test_nested();
      do_reset();
      push_and_tick(1, 6, 2);
      chk("R6", "loop_depth outer", int'(loop_depth), 1);
      push_and_tick(2, 3, 2);
      chk("R6", "fetch_pc", int'(fetch_pc), 2);
      chk("R6", "loop_depth inner", int'(loop_depth), 2);
      expect_pc(3, "R6");
      expect_pc(2, "R6");
      expect_pc(3, "R6");
      expect_pc(4, "R6");
      chk("R6", "loop_depth after inner", int'(loop_depth), 1);
      expect_pc(5, "R6");
      expect_pc(6, "R6");
      expect_pc(1, "R6");
      chk("R6", "loop_depth outer resumed", int'(loop_depth), 1);
      push_and_tick(2, 3, 2);
      chk("R6", "fetch_pc", int'(fetch_pc), 2);
      chk("R6", "loop_depth inner again", int'(loop_depth), 2);
      expect_pc(3, "R6");
      expect_pc(2, "R6");
      expect_pc(3, "R6");
      expect_pc(4, "R6");
      expect_pc(5, "R6");
      expect_pc(6, "R6");
      expect_pc(7, "R6");
      chk("R6", "loop_depth all done", int'(loop_depth), 0);
   endtask

   // R7 and R8: full stack, dropped push, branches
   task automatic test_overflow_branch();
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         push_and_tick(300 + 10 * i, 305 + 10 * i, 2);
      end
      chk("R6", "loop_depth full", int'(loop_depth), DEPTH);
      chk("R7", "loop_ovf before extra push", int'(loop_ovf), 0);
      push_and_tick(50, 60, 5);
      chk("R7", "loop_ovf after extra push", int'(loop_ovf), 1);
      chk("R7", "loop_depth after extra push", int'(loop_depth), DEPTH);
      branch_and_tick(354);
      chk("R8", "fetch_pc after branch", int'(fetch_pc), 354);
      chk("R8", "dec_valid after branch", int'(dec_valid), 0);
      chk("R8", "exe_valid after branch", int'(exe_valid), 0);
      expect_pc(355, "R8");
      chk("R8", "dec_valid refills", int'(dec_valid), 1);
      expect_pc(350, "R7");
      chk("R7", "loop_ovf stays set", int'(loop_ovf), 1);
      expect_pc(351, "R7");
      expect_pc(352, "R7");
      expect_pc(353, "R7");
      expect_pc(354, "R7");
      expect_pc(355, "R7");
      branch_and_tick(500);
      chk("R8", "fetch_pc branch at loop end", int'(fetch_pc), 500);
      chk("R8", "loop_depth kept on branch", int'(loop_depth), DEPTH);
      chk("R8", "dec_valid flushed", int'(dec_valid), 0);
      do_reset();
   endtask

   // R10: push in the cycle the innermost loop retires
   task automatic test_push_on_pop();
      do_reset();
      push_and_tick(1, 2, 1);
      expect_pc(2, "R10");
      push_and_tick(5, 6, 2);
      chk("R4", "fetch_pc falls through", int'(fetch_pc), 3);
      chk("R10", "loop_depth swap", int'(loop_depth), 1);
      expect_pc(4, "R10");
      expect_pc(5, "R10");
      expect_pc(6, "R10");
      expect_pc(5, "R10");
      expect_pc(6, "R10");
      expect_pc(7, "R10");
      chk("R10", "loop_depth after swap loop", int'(loop_depth), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      test_sequential();
      test_single_loop();
      test_zero_count();
      test_nested();
      test_overflow_branch();
      test_push_on_pop();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule